// File: doc/BRIEF.md
# Serial Register Slave with Strobe-Marked Commands

This block is the device-side end of a four-wire serial register link. A host drives a serial clock, an active-low strobe and a data-in line, and reads back a data-out line that is pulled up externally. The slave sits in front of a small map of 32-bit registers. It drives the stored read/write registers onto its outputs so that board logic can use them. It also raises a reset request pulse for the system.

No chip select frames a transfer. While the strobe is high, every bit clocked in is appended to a running 40-bit history. The one clock cycle during which the strobe is low is the command cycle, and its data-in bit gives the direction: 0 means read and 1 means write. The slave decodes from the tail of the history. The lowest 8 bits are the address and, for a write, the 32 bits above them are the data. On a write the host therefore sends the data first and the address second.

On a read, the addressed register goes out MSB first on data-out, one bit for each following clock cycle. All serial inputs are resampled by a faster system clock, and the edges of the serial clock are detected in that clock domain.

Top module: `scpld_slave`

## Requirements
- R1: After reset, data-out is 1, the mode, multiplexer, display-setting and reset registers read 0, and the reset request is low.
- R2: A bit is captured on each rising serial-clock edge. With the strobe high it joins the history, MSB first. With the strobe low it is a command bit: 1 means write and 0 means read. A read frame leaves every register unchanged.
- R3: A write frame has 32 data bits, then 8 address bits, then the command cycle. It stores the data into the addressed read/write register: mode at 0x00, multiplexer at 0x01, display setting at 0x02, reset at 0x80. The new value appears on the matching output before the next serial bit.
- R4: A read frame has 8 address bits, then the command cycle with data-in at 0. After the falling edge of the command cycle, data-out carries the register MSB. Each later falling edge moves to the next lower bit, so a host sampling while the clock is high receives the 32-bit value MSB first.
- R5: After the 32nd data bit has been clocked out, data-out returns to 1 and stays there until the next read command.
- R6: A read of 0x08 returns the 32-bit switch input. Writes to 0x08 and to 0xFF change nothing.
- R7: A read of 0xFF returns the VERSION parameter.
- R8: A read of any other address returns 0. A write to any other address leaves all registers unchanged.
- R9: A write to 0x80 with bit 0 set raises the reset request for exactly RST_PULSE_CYC system clocks (default 16). A write with bit 0 clear raises no pulse. The reset register reads back the value written.
- R10: Bits clocked with the strobe high never change a register, the reset request or data-out, however many of them there are.
- R11: Only the last 40 history bits before the command cycle count. Any number of earlier bits has no effect on the decoded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, idles low |
| ser_stb_n | input | 1 | Command strobe, active low, idles high |
| ser_din | input | 1 | Serial data from the host, idles low |
| ser_dout | output | 1 | Serial data to the host, 1 when idle |
| sw_in | input | 32 | Switch inputs, readable at 0x08 |
| mode_q | output | 32 | Mode register contents |
| mux_q | output | 32 | Multiplexer register contents |
| disp_q | output | 32 | Display-setting register contents |
| rst_reg_q | output | 32 | Reset register contents |
| sys_rst_req | output | 1 | Reset request pulse |

## Verification
Writes use data words of different shapes: alternating bits, all ones, a single low byte and a counting pattern. Each word is read back through the serial port, so a bit-order or off-by-one shift error shows up as a wrong word rather than a matching one. Reads of the switch, version and unmapped addresses separate the three read sources from the stored registers. Writes to read-only and unmapped addresses are followed by reads of every stored register to show that nothing moved. A long stream with the strobe held high, and a write preceded by junk bits, show that only the tail of the history is decoded. Writing 0 and then 1 to the reset register separates the pulse trigger from the stored value.

// File: rtl/scpld_pkg.sv
package scpld_pkg;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int HIST_W = DW + AW;

    localparam logic [AW-1:0] A_MODE = 8'h00;
    localparam logic [AW-1:0] A_MUX  = 8'h01;
    localparam logic [AW-1:0] A_DISP = 8'h02;
    localparam logic [AW-1:0] A_SW   = 8'h08;
    localparam logic [AW-1:0] A_RST  = 8'h80;
    localparam logic [AW-1:0] A_VER  = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_MODE, SEL_MUX, SEL_DISP, SEL_SW, SEL_RST, SEL_VER
    } reg_sel_e;

    typedef struct packed {
        logic          valid;
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            A_MODE:  return SEL_MODE;
            A_MUX:   return SEL_MUX;
            A_DISP:  return SEL_DISP;
            A_SW:    return SEL_SW;
            A_RST:   return SEL_RST;
            A_VER:   return SEL_VER;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_writable(input reg_sel_e s);
        return (s == SEL_MODE) || (s == SEL_MUX) || (s == SEL_DISP) || (s == SEL_RST);
    endfunction
endpackage

// File: rtl/scpld_sync.sv
module scpld_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d_in[b]};
        end
        assign d_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/scpld_frame.sv
module scpld_frame
    import scpld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic stb_n_s,
    input  logic din_s,
    output logic sclk_fall,
    output cmd_t cmd
);
    logic              sclk_d;
    logic              sclk_rise;
    logic [HIST_W-1:0] hist;
    logic              pend;
    logic              pend_wr;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            hist    <= '0;
            pend    <= 1'b0;
            pend_wr <= 1'b0;
            cmd     <= '0;
        end else begin
            sclk_d    <= sclk_s;
            cmd.valid <= 1'b0;
            if (sclk_rise) begin
                if (stb_n_s) begin
                    hist <= {hist[HIST_W-2:0], din_s};
                end else begin
                    pend    <= 1'b1;
                    pend_wr <= din_s;
                end
            end
            if (sclk_fall && pend) begin
                pend      <= 1'b0;
                cmd.valid <= 1'b1;
                cmd.is_wr <= pend_wr;
                cmd.addr  <= hist[AW-1:0];
                cmd.data  <= hist[HIST_W-1:AW];
            end
        end
    end
endmodule

// File: rtl/scpld_regs.sv
module scpld_regs
    import scpld_pkg::*;
#(
    parameter logic [DW-1:0] VERSION       = 32'h0001_0203,
    parameter int            RST_PULSE_CYC = 16,
    parameter int            SYNC_STAGES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic [DW-1:0] sw_in,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] mux_q,
    output logic [DW-1:0] disp_q,
    output logic [DW-1:0] rst_reg_q,
    output logic          sys_rst_req
);
    localparam int PW = $clog2(RST_PULSE_CYC + 1);

    reg_sel_e      sel;
    logic          wr_en;
    logic [DW-1:0] sw_s;
    logic [PW-1:0] pulse_cnt;

    scpld_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (sw_in),
        .d_out (sw_s)
    );

    assign sel   = decode_addr(cmd.addr);
    assign wr_en = cmd.valid && cmd.is_wr && is_writable(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            mux_q     <= '0;
            disp_q    <= '0;
            rst_reg_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: mode_q    <= cmd.data;
                SEL_MUX:  mux_q     <= cmd.data;
                SEL_DISP: disp_q    <= cmd.data;
                SEL_RST:  rst_reg_q <= cmd.data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                    pulse_cnt <= '0;
        else if (wr_en && sel == SEL_RST && cmd.data[0]) pulse_cnt <= PW'(RST_PULSE_CYC);
        else if (pulse_cnt != '0)                   pulse_cnt <= pulse_cnt - 1'b1;
    end

    assign sys_rst_req = (pulse_cnt != '0);

    always_comb begin
        case (sel)
            SEL_MODE: rd_data = mode_q;
            SEL_MUX:  rd_data = mux_q;
            SEL_DISP: rd_data = disp_q;
            SEL_SW:   rd_data = sw_s;
            SEL_RST:  rd_data = rst_reg_q;
            SEL_VER:  rd_data = VERSION;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/scpld_shiftout.sv
module scpld_shiftout
    import scpld_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sclk_fall,
    output logic          dout
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] sh;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
            dout <= 1'b1;
        end else if (load) begin
            sh   <= load_data;
            left <= CW'(DW);
            dout <= load_data[DW-1];
        end else if (sclk_fall && left != '0) begin
            sh   <= {sh[DW-2:0], 1'b0};
            left <= left - 1'b1;
            dout <= (left > CW'(1)) ? sh[DW-2] : 1'b1;
        end
    end
endmodule

// File: rtl/scpld_slave.sv
module scpld_slave
    import scpld_pkg::*;
#(
    parameter logic [31:0] VERSION       = 32'h0001_0203,
    parameter int          RST_PULSE_CYC = 16,
    parameter int          SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_stb_n,
    input  logic        ser_din,
    output logic        ser_dout,
    input  logic [31:0] sw_in,
    output logic [31:0] mode_q,
    output logic [31:0] mux_q,
    output logic [31:0] disp_q,
    output logic [31:0] rst_reg_q,
    output logic        sys_rst_req
);
    logic [2:0]    ser_s;
    logic          sclk_fall;
    cmd_t          cmd;
    logic [DW-1:0] rd_data;

    scpld_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({ser_clk, ser_stb_n, ser_din}),
        .d_out (ser_s)
    );

    scpld_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (ser_s[2]),
        .stb_n_s   (ser_s[1]),
        .din_s     (ser_s[0]),
        .sclk_fall (sclk_fall),
        .cmd       (cmd)
    );

    scpld_regs #(
        .VERSION       (VERSION),
        .RST_PULSE_CYC (RST_PULSE_CYC),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .sw_in       (sw_in),
        .rd_data     (rd_data),
        .mode_q      (mode_q),
        .mux_q       (mux_q),
        .disp_q      (disp_q),
        .rst_reg_q   (rst_reg_q),
        .sys_rst_req (sys_rst_req)
    );

    scpld_shiftout u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.valid && !cmd.is_wr),
        .load_data (rd_data),
        .sclk_fall (sclk_fall),
        .dout      (ser_dout)
    );
endmodule

// File: rtl/scpld_checker.sv
module scpld_checker
    import scpld_pkg::*;
#(
    parameter int RST_PULSE_CYC = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ser_dout,
    input logic          sclk_fall,
    input cmd_t          cmd,
    input logic          sys_rst_req,
    input logic [DW-1:0] mode_q,
    input logic [DW-1:0] mux_q
);
    logic [15:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)              hi_len <= '0;
        else if (sys_rst_req) hi_len <= hi_len + 1'b1;
        else                  hi_len <= '0;
    end

    // R1
    rst_dout_chk: assert property (@(posedge clk) rst |=> ser_dout);

    // R4
    dout_moves_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(sclk_fall) && !$past(cmd.valid)) |-> $stable(ser_dout));

    // R3
    mux_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.is_wr && cmd.addr == A_MUX) |=> (mux_q == $past(cmd.data)));

    // R6
    mode_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(cmd.valid && cmd.is_wr && cmd.addr == A_MODE));

    // R9
    rst_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> $past(cmd.valid && cmd.is_wr && cmd.addr == A_RST && cmd.data[0]));

    // R9
    rst_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_req) |-> (hi_len >= 16'(RST_PULSE_CYC)));
endmodule

bind scpld_slave scpld_checker #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_dout    (ser_dout),
    .sclk_fall   (sclk_fall),
    .cmd         (cmd),
    .sys_rst_req (sys_rst_req),
    .mode_q      (mode_q),
    .mux_q       (mux_q)
);

// File: tb/scpld_slave_bench.sv
`timescale 1ns/1ps
module scpld_slave_bench;
    localparam int          H   = 8;
    localparam logic [31:0] VER = 32'h0001_0203;
    localparam logic [31:0] SW  = 32'hA5C3_0F96;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_stb_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic [31:0] sw_in = SW;
    logic [31:0] mode_q, mux_q, disp_q, rst_reg_q;
    logic        sys_rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int pulses = 0;
    int run_len = 0;
    int last_len = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] got_q[$];

    always #10 clk = ~clk;

    scpld_slave u_scpld_slave (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_stb_n(ser_stb_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .sw_in(sw_in),
        .mode_q(mode_q), .mux_q(mux_q), .disp_q(disp_q),
        .rst_reg_q(rst_reg_q), .sys_rst_req(sys_rst_req)
    );

    always @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
        end else if (sys_rst_req) begin
            run_len <= run_len + 1;
        end else if (run_len != 0) begin
            pulses   <= pulses + 1;
            last_len <= run_len;
            run_len  <= 0;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_bit(input logic d, input logic stb_n, output logic q);
        @(negedge clk);
        ser_din   = d;
        ser_stb_n = stb_n;
        repeat (H) @(negedge clk);
        ser_clk = 1'b1;
        repeat (H) @(negedge clk);
        q = ser_dout;
        ser_clk = 1'b0;
        repeat (H) @(negedge clk);
        ser_stb_n = 1'b1;
        ser_din   = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [31:0] data);
        logic q;
        for (int i = 31; i >= 0; i--) host_bit(data[i], 1'b1, q);
        for (int i = 7; i >= 0; i--) host_bit(addr[i], 1'b1, q);
        host_bit(1'b1, 1'b0, q);
    endtask

    task automatic do_read(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        logic q;
        logic [31:0] w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) host_bit(addr[i], 1'b1, q);
        host_bit(1'b0, 1'b0, q);
        for (int i = 31; i >= 0; i--) begin
            host_bit(1'b0, 1'b1, q);
            w[i] = q;
        end
        got_q.push_back(w);
    endtask

    initial begin : monitor
        logic [31:0] g, e;
        string t;
        forever begin
            wait (got_q.size() != 0);
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g, e, t);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic q;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({31'd0, ser_dout}, 32'd1, "R1 dout idle");
        chk(mode_q | mux_q | disp_q | rst_reg_q, 32'd0, "R1 regs zero");
        chk({31'd0, sys_rst_req}, 32'd0, "R1 no reset req");
        do_read(8'h00, 32'd0, "R1 read mode after reset");

        do_write(8'h00, 32'h5555_AAAA);
        chk(mode_q, 32'h5555_AAAA, "R3 mode write");
        do_write(8'h01, 32'hFFFF_FFFF);
        chk(mux_q, 32'hFFFF_FFFF, "R3 mux write");
        do_write(8'h02, 32'h0000_00C3);
        chk(disp_q, 32'h0000_00C3, "R3 disp write");
        do_read(8'h00, 32'h5555_AAAA, "R4 read mode");
        do_read(8'h01, 32'hFFFF_FFFF, "R4 read mux");
        do_read(8'h02, 32'h0000_00C3, "R4 read disp");
        chk(mux_q, 32'hFFFF_FFFF, "R2 read frame leaves mux");
        repeat (4 * H) @(negedge clk);
        chk({31'd0, ser_dout}, 32'd1, "R5 dout released");

        do_read(8'h08, SW, "R6 switch read");
        do_write(8'h08, 32'h1234_5678);
        do_write(8'hFF, 32'h8765_4321);
        do_read(8'h08, SW, "R6 switch unchanged");
        do_read(8'hFF, VER, "R7 version read");
        chk(mode_q, 32'h5555_AAAA, "R6 mode kept");

        do_read(8'h05, 32'd0, "R8 unmapped 05");
        do_read(8'h7F, 32'd0, "R8 unmapped 7F");
        do_write(8'h03, 32'hDEAD_BEEF);
        do_read(8'h00, 32'h5555_AAAA, "R8 mode after unmapped write");
        do_read(8'h01, 32'hFFFF_FFFF, "R8 mux after unmapped write");
        do_read(8'h02, 32'h0000_00C3, "R8 disp after unmapped write");

        for (int i = 0; i < 50; i++) host_bit(((i * 7) % 3) == 0, 1'b1, q);
        chk(mode_q, 32'h5555_AAAA, "R10 mode after stream");
        chk(mux_q, 32'hFFFF_FFFF, "R10 mux after stream");
        chk(disp_q, 32'h0000_00C3, "R10 disp after stream");
        chk({31'd0, ser_dout}, 32'd1, "R10 dout idle");
        chk(pulses, 0, "R10 no pulse");

        for (int i = 0; i < 20; i++) host_bit(1'b1, 1'b1, q);
        do_write(8'h02, 32'h0102_0304);
        chk(disp_q, 32'h0102_0304, "R11 tail decode");
        do_read(8'h02, 32'h0102_0304, "R11 read back");

        do_write(8'h80, 32'h0000_0002);
        repeat (40) @(negedge clk);
        chk(pulses, 0, "R9 bit0 clear no pulse");
        chk(rst_reg_q, 32'h0000_0002, "R9 reset reg value");
        do_write(8'h80, 32'h0000_0001);
        repeat (40) @(negedge clk);
        chk(pulses, 1, "R9 one pulse");
        chk(last_len, 16, "R9 pulse length");
        do_read(8'h80, 32'h0000_0001, "R9 reset reg read");

        wait (got_q.size() == 0 && exp_q.size() == 0);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule